// File: doc/BRIEF.md
# Moderated Interrupt Cause Register

This block collects hardware interrupt events into a vector of sticky cause bits. Software can clear a bit in two ways: it can write a one to it, or it can read the register, which clears the bits it returned. A third way needs no software access. Each bit picked in an auto-clear mask register clears itself when the block hands an interrupt message to the fabric. Because of this, an interrupt handler that learns the cause from the message vector never touches the cause register.

Interrupt messages are paced by a moderation countdown. The block raises a message request, with a vector index, only when the countdown sits at zero and at least one enabled cause is pending. The request uses a valid/ready handshake. On the accepting cycle the countdown reloads from a programmable interval, and every cause bit marked auto-clear is dropped.

A second, legacy cause register runs next to the extended one. It keeps the same set behaviour and the same read and write clear paths, but the message handshake never clears it.

Top module: `irq_cause_mod`

## Requirements
- R1: A cause event sets its bit whatever the auto-clear mask holds. If an event and any clear (write, read or auto-clear) hit the same bit in the same cycle, the bit stays 1.
- R2: A write to select 0 (extended causes) or select 1 (legacy causes) clears exactly the bits whose data bit is 1 and leaves every other bit unchanged.
- R3: A read of select 0 or select 1 returns the current value in the same cycle. At the following clock edge it clears only the bits it returned as 1.
- R4: An accepted message request never changes the legacy cause register.
- R5: `msg_valid` rises only when the countdown is zero and the cause register ANDed with the enable mask (select 3) is non-zero. A pending event asserts it at the second clock edge after the event. With no enabled cause pending, it stays low.
- R6: On an accepted request (`msg_valid` and `msg_ready` both 1), every extended cause bit that is set in the auto-clear mask (select 2) is cleared. All other extended bits are kept.
- R7: `msg_vec` is the lowest index among the enabled pending causes at the edge where `msg_valid` rises. `msg_valid` and `msg_vec` hold steady until the request is accepted.
- R8: An accepted request loads the countdown from the interval register (select 4). The next request can rise no earlier than interval+1 edges after the accepting edge. An interval of 0 allows a new request at the very next edge. While idle the countdown stops at zero.
- R9: Selects 2, 3 and 4 are read/write, and reading them does not change them. All registers reset to zero. A read of any unused select returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_cause | input | N_CAUSE | Extended cause events, one cycle each |
| ev_legacy | input | N_LEGACY | Legacy cause events |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 3 | Register select (0 causes, 1 legacy, 2 auto-clear mask, 3 enable mask, 4 interval) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the read strobe |
| msg_valid | output | 1 | Interrupt message request |
| msg_ready | input | 1 | Fabric accepts the request |
| msg_vec | output | VEC_W | Vector index of the request |

## Verification
A cause bit that is stuck or lost shows up on `bus_rdata` at the next read of its select. It also shows up through the message path: a missing `msg_valid` two edges after an enabled event, or a `msg_vec` pointing at the wrong index. A countdown that reloads badly or fails to stop moves the rising edge of `msg_valid` away from interval+1 edges after the accepting edge. The bench counts those edges exactly. A bad auto-clear mask, or a clear that leaks into the legacy register, becomes visible at the first read after a handshake.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

    localparam int BUS_W = 16;

    typedef enum logic [2:0] {
        SEL_CAUSE    = 3'd0,
        SEL_LEGACY   = 3'd1,
        SEL_AUTOCLR  = 3'd2,
        SEL_ENABLE   = 3'd3,
        SEL_INTERVAL = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        reg_sel_e         sel;
        logic [BUS_W-1:0] data;
    } bus_req_t;

    // index of the lowest set bit, zero when none
    function automatic logic [4:0] lowest_one(input logic [31:0] v);
        logic [4:0] idx;
        idx = '0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) idx = 5'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else begin
                // set dominates any clear in the same cycle
                bit_q <= set_i[g] | (bit_q & ~clr_i[g]);
            end
        end
        assign q_o[g] = bit_q;
    end
endmodule

// File: rtl/irq_mod_timer.sv
module irq_mod_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] ival_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= ival_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/irq_msg_req.sv
module irq_msg_req
    import irq_cause_pkg::*;
#(
    parameter int N  = 8,
    parameter int VW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  pend_i,
    input  logic          zero_i,
    input  logic          ready_i,
    output logic          valid_o,
    output logic [VW-1:0] vec_o,
    output logic          fire_o
);
    logic          valid_q;
    logic [VW-1:0] vec_q;
    logic [VW-1:0] pick;

    assign pick   = VW'(lowest_one(32'(pend_i)));
    assign fire_o = valid_q & ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            vec_q   <= '0;
        end else if (fire_o) begin
            valid_q <= 1'b0;
        end else if (!valid_q && zero_i && (pend_i != '0)) begin
            valid_q <= 1'b1;
            vec_q   <= pick;
        end
    end

    assign valid_o = valid_q;
    assign vec_o   = vec_q;
endmodule

// File: rtl/irq_cause_mod.sv
module irq_cause_mod
    import irq_cause_pkg::*;
#(
    parameter int N_CAUSE  = 8,
    parameter int N_LEGACY = 8,
    parameter int TMR_W    = 16,
    localparam int VEC_W   = (N_CAUSE > 1) ? $clog2(N_CAUSE) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_CAUSE-1:0]  ev_cause,
    input  logic [N_LEGACY-1:0] ev_legacy,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [2:0]          bus_sel,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [VEC_W-1:0]    msg_vec
);
    bus_req_t req;
    assign req = '{wr: bus_wr, rd: bus_rd, sel: reg_sel_e'(bus_sel), data: bus_wdata};

    logic [N_CAUSE-1:0]  cause_q, ac_q, en_q, cause_clr;
    logic [N_LEGACY-1:0] legacy_q, legacy_clr;
    logic [TMR_W-1:0]    ival_q;
    logic                fire, tmr_zero;

    // register strobes
    logic wr_cause, rd_cause, wr_leg, rd_leg;
    assign wr_cause = req.wr && (req.sel == SEL_CAUSE);
    assign rd_cause = req.rd && (req.sel == SEL_CAUSE);
    assign wr_leg   = req.wr && (req.sel == SEL_LEGACY);
    assign rd_leg   = req.rd && (req.sel == SEL_LEGACY);

    // clear vectors, three sources for the extended set, two for legacy
    assign cause_clr  = (wr_cause ? req.data[N_CAUSE-1:0] : '0)
                      | (rd_cause ? cause_q : '0)
                      | (fire     ? ac_q    : '0);
    assign legacy_clr = (wr_leg ? req.data[N_LEGACY-1:0] : '0)
                      | (rd_leg ? legacy_q : '0);

    irq_cause_bank #(.W(N_CAUSE)) u_cause (
        .clk(clk), .rst(rst), .set_i(ev_cause), .clr_i(cause_clr), .q_o(cause_q)
    );

    irq_cause_bank #(.W(N_LEGACY)) u_legacy (
        .clk(clk), .rst(rst), .set_i(ev_legacy), .clr_i(legacy_clr), .q_o(legacy_q)
    );

    // plain read/write control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ac_q   <= '0;
            en_q   <= '0;
            ival_q <= '0;
        end else if (req.wr) begin
            unique case (req.sel)
                SEL_AUTOCLR:  ac_q   <= req.data[N_CAUSE-1:0];
                SEL_ENABLE:   en_q   <= req.data[N_CAUSE-1:0];
                SEL_INTERVAL: ival_q <= req.data[TMR_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (req.rd) begin
            case (req.sel)
                SEL_CAUSE:    bus_rdata[N_CAUSE-1:0]  = cause_q;
                SEL_LEGACY:   bus_rdata[N_LEGACY-1:0] = legacy_q;
                SEL_AUTOCLR:  bus_rdata[N_CAUSE-1:0]  = ac_q;
                SEL_ENABLE:   bus_rdata[N_CAUSE-1:0]  = en_q;
                SEL_INTERVAL: bus_rdata[TMR_W-1:0]    = ival_q;
                default:      bus_rdata = '0;
            endcase
        end
    end

    irq_mod_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .load_i(fire), .ival_i(ival_q), .zero_o(tmr_zero)
    );

    irq_msg_req #(.N(N_CAUSE), .VW(VEC_W)) u_req (
        .clk(clk), .rst(rst), .pend_i(cause_q & en_q), .zero_i(tmr_zero),
        .ready_i(msg_ready), .valid_o(msg_valid), .vec_o(msg_vec), .fire_o(fire)
    );
endmodule

// File: rtl/irq_cause_mod_chk.sv
module irq_cause_mod_chk #(
    parameter int N  = 8,
    parameter int L  = 8,
    parameter int TW = 16,
    parameter int VW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  ev_cause,
    input logic [L-1:0]  ev_legacy,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic          msg_valid,
    input logic          msg_ready,
    input logic [VW-1:0] msg_vec,
    input logic [N-1:0]  cause_q,
    input logic [N-1:0]  ac_q,
    input logic [N-1:0]  en_q,
    input logic [L-1:0]  legacy_q,
    input logic [TW-1:0] ival_q
);
    logic          hs;
    logic [TW:0]   gap;
    logic [TW-1:0] cap;
    logic          seen;

    assign hs = msg_valid && msg_ready;

    // cycles since the last accepted request
    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            cap  <= '0;
            seen <= 1'b0;
        end else if (hs) begin
            gap  <= '0;
            cap  <= ival_q;
            seen <= 1'b1;
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (ev_cause != '0) |=> ((cause_q & $past(ev_cause)) == $past(ev_cause))); // R1

    AST_LEGACY_KEPT: assert property (@(posedge clk) disable iff (rst)
        (hs && !bus_rd && !bus_wr) |=> (legacy_q == $past(legacy_q | ev_legacy))); // R4

    AST_REQ_PENDING: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> ((($past(cause_q & en_q) >> msg_vec) & N'(1)) != '0)); // R5

    AST_AUTO_CLEARED: assert property (@(posedge clk) disable iff (rst)
        hs |=> ((cause_q & $past(ac_q) & ~$past(ev_cause)) == '0)); // R6

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vec))); // R7

    AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
        (seen && $rose(msg_valid)) |-> (gap > {1'b0, cap})); // R8
endmodule

bind irq_cause_mod irq_cause_mod_chk #(
    .N(N_CAUSE), .L(N_LEGACY), .TW(TMR_W), .VW(VEC_W)
) u_chk (
    .clk(clk), .rst(rst), .ev_cause(ev_cause), .ev_legacy(ev_legacy),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vec(msg_vec), .cause_q(cause_q), .ac_q(ac_q), .en_q(en_q),
    .legacy_q(legacy_q), .ival_q(ival_q)
);

// File: tb/test_irq_cause_mod.sv
module test_irq_cause_mod;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ev_cause = '0;
    logic [7:0]  ev_legacy = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [2:0]  msg_vec;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #10 clk = ~clk; // 50 MHz

    irq_cause_mod i_irq_cause_mod (
        .clk(clk), .rst(rst), .ev_cause(ev_cause), .ev_legacy(ev_legacy),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vec(msg_vec)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad = bad + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad + 0);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] sel, input logic [15:0] exp, input string req);
        bus_rd = 1'b1; bus_sel = sel;
        #2 chk(req, 32'(bus_rdata), 32'(exp));
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] e, input logic [7:0] l);
        ev_cause = e; ev_legacy = l;
        tick();
        ev_cause = '0; ev_legacy = '0;
    endtask

    task automatic accept();
        msg_ready = 1'b1;
        tick();
        msg_ready = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  op;   // 0 idle, 1 write, 2 read
        logic [2:0]  sel;
        logic [15:0] wd;
        logic [7:0]  ev;
        logic [7:0]  evl;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 3'd2, 16'h000F, 8'h00, 8'h00, 16'h0000, 4'd9}, // auto-clear mask 0x0F
        '{2'd0, 3'd0, 16'h0000, 8'hA5, 8'h3C, 16'h0000, 4'd1},
        '{2'd2, 3'd0, 16'h0000, 8'h00, 8'h00, 16'h00A5, 4'd1}, // R1 masked bits still set
        '{2'd2, 3'd0, 16'h0000, 8'h00, 8'h00, 16'h0000, 4'd3}, // R3 read cleared
        '{2'd2, 3'd1, 16'h0000, 8'h00, 8'h01, 16'h003C, 4'd3}, // read with event
        '{2'd2, 3'd1, 16'h0000, 8'h00, 8'h00, 16'h0001, 4'd1}, // event beat read clear
        '{2'd0, 3'd0, 16'h0000, 8'hFF, 8'hF0, 16'h0000, 4'd1},
        '{2'd1, 3'd0, 16'h0033, 8'h01, 8'h00, 16'h0000, 4'd2}, // R2 w1c with event on bit 0
        '{2'd2, 3'd0, 16'h0000, 8'h00, 8'h00, 16'h00CD, 4'd2},
        '{2'd1, 3'd1, 16'h0030, 8'h00, 8'h00, 16'h0000, 4'd2},
        '{2'd2, 3'd1, 16'h0000, 8'h00, 8'h00, 16'h00C0, 4'd2},
        '{2'd2, 3'd2, 16'h0000, 8'h00, 8'h00, 16'h000F, 4'd9}, // R9 non-destructive
        '{2'd2, 3'd2, 16'h0000, 8'h00, 8'h00, 16'h000F, 4'd9},
        '{2'd1, 3'd4, 16'h0005, 8'h00, 8'h00, 16'h0000, 4'd9},
        '{2'd2, 3'd4, 16'h0000, 8'h00, 8'h00, 16'h0005, 4'd9},
        '{2'd2, 3'd3, 16'h0000, 8'h00, 8'h00, 16'h0000, 4'd9}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state, R9
        chk("R9 reset valid", 32'(msg_valid), 0);
        for (int s = 0; s < 6; s++) rd(3'(s), 16'h0, "R9 reset value");

        // table walk, no cause enabled so no request may appear (R5)
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = TBL[i];
            tag = $sformatf("R%0d table %0d", v.req, i);
            ev_cause = v.ev; ev_legacy = v.evl;
            bus_sel = v.sel; bus_wdata = v.wd;
            bus_wr = (v.op == 2'd1); bus_rd = (v.op == 2'd2);
            #2;
            if (v.op == 2'd2) chk(tag, 32'(bus_rdata), 32'(v.exp));
            tick();
            bus_wr = 1'b0; bus_rd = 1'b0; ev_cause = '0; ev_legacy = '0;
            chk("R5 disabled no request", 32'(msg_valid), 0);
        end

        // message path setup
        wr(3'd2, 16'h000F);
        wr(3'd4, 16'd3);
        wr(3'd0, 16'h00FF);
        wr(3'd1, 16'h00FF);
        wr(3'd3, 16'h00FF);

        pulse(8'h14, 8'h81);
        chk("R5 one edge after event", 32'(msg_valid), 0);
        tick();
        chk("R5 request raised", 32'(msg_valid), 1);
        chk("R7 lowest vector", 32'(msg_vec), 2);
        tick(); tick();
        chk("R7 held valid", 32'(msg_valid), 1);
        chk("R7 held vector", 32'(msg_vec), 2);
        accept();
        chk("R6 dropped after accept", 32'(msg_valid), 0);
        rd(3'd0, 16'h0010, "R6 auto-clear bits only");
        rd(3'd1, 16'h0081, "R4 legacy untouched");
        for (int k = 0; k < 6; k++) begin
            tick();
            chk("R5 idle no request", 32'(msg_valid), 0);
        end

        // countdown spacing, bit 5 not auto-clear so it stays pending
        pulse(8'h20, 8'h00);
        tick();
        chk("R5 request bit5", 32'(msg_valid), 1);
        chk("R7 vector 5", 32'(msg_vec), 5);
        accept();
        chk("R8 low at accept", 32'(msg_valid), 0);
        for (int k = 1; k <= 3; k++) begin
            tick();
            chk("R8 countdown", 32'(msg_valid), 0);
        end
        tick();
        chk("R8 request after interval", 32'(msg_valid), 1);
        chk("R8 vector after interval", 32'(msg_vec), 5);

        // interval 0, clear bit 5 while request pends
        wr(3'd4, 16'd0);
        wr(3'd0, 16'h0020);
        chk("R7 still held", 32'(msg_valid), 1);
        accept();
        tick();
        chk("R5 nothing pending", 32'(msg_valid), 0);

        // event on an auto-clear bit in the handshake cycle survives
        pulse(8'h02, 8'h00);
        tick();
        chk("R7 vector 1", 32'(msg_vec), 1);
        msg_ready = 1'b1; ev_cause = 8'h08;
        tick();
        msg_ready = 1'b0; ev_cause = '0;
        chk("R6 accept drop", 32'(msg_valid), 0);
        tick();
        chk("R1 R8 next request interval 0", 32'(msg_valid), 1);
        chk("R1 surviving bit vector", 32'(msg_vec), 3);
        accept();
        rd(3'd0, 16'h0000, "R6 all auto-clear gone");

        // enable mask gates requests
        wr(3'd3, 16'h00FE);
        pulse(8'h01, 8'h00);
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R5 masked cause", 32'(msg_valid), 0);
        end
        rd(3'd0, 16'h0001, "R1 masked bit still recorded");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule